// File: doc/BRIEF.md
# Dual-Input AC-Link Frame Receiver

This block receives the inbound half of an AC '97 link that carries two serial data lines, one from a primary codec and one from a secondary codec. The bit clock, the frame marker and both data lines are sampled in the system clock domain. Each 256-bit frame is cut into a 16-bit tag slot and twelve 20-bit slots, one deserializer per line. When a frame ends, the slots of the two lines are merged into one slot image. The merge relies on the rule that the two codecs never mark the same data slot valid.

From each frame the receiver extracts several things: the ready flag of each codec, the slot request bits, any register read-back from slot 1 and slot 2, and the GPIO word from slot 12. The GPIO word is kept in a shadow register. A simple host-side read port returns codec register contents. Reads of the GPIO pin status register are answered at once from the shadow. All other reads stay pending until the addressed codec returns a matching read-back.

Top module: `ac_dual_rx`

## Requirements
- R1: `ready_o[i]` takes bit 15 of slot 0 received on `sdi_i[i]`, updated once per frame, in the same cycle as the one-cycle `frame_o` pulse.
- R2: Slot k (1..12) counts as tagged on a line when bit 15-k of that line's slot 0 is set. `slot_valid_o[k-1]` is the OR of both lines' tags. `slot_data_o[(k-1)*20 +: 20]` holds the slot word, MSB first, taken from the line that tagged it, or zero when neither line did.
- R3: When both lines tag the same slot 1..12 in one frame, the word from line 0 is used and `overlap_o` is 1 for that frame. Otherwise `overlap_o` is 0.
- R4: Slot 1 bits 11..2 are active-low slot requests for slots 3..12, with bit 11 for slot 3. `slot_req_o[j]` (slot 3+j) is set when any line whose ready flag is set in that frame requests it. Requests are decoded whatever the slot 1 tag.
- R5: A read request of any other register makes `rd_busy_o` rise. Address bit 7 selects the line: 0 for line 0, 1 for line 1. The read completes in the first frame in which that line tags slot 1 and slot 1 bits 18..12 equal address bits 6..0. At that point `rd_data_o` takes slot 2 bits 19..4, and `rd_done_o` pulses together with `frame_o` while `rd_busy_o` falls.
- R6: Read-backs with the slot 1 tag clear, with a different index, or arriving on the other line are ignored and leave `rd_busy_o` high. A read request made while busy is ignored.
- R7: Slot 12 bits 19..4 are copied into `gpio_shadow_o` in each frame that tags slot 12. A read request whose address bits 6..0 equal 54h (so both 54h and D4h) gives `rd_done_o` in the next cycle, with the shadow value and no link wait.
- R8: A GPIO read accepted in the cycle in which a frame commits a new slot 12 returns the new value. Its `rd_done_o` then coincides with `frame_o`.
- R9: Reset clears the ready flags, the shadow, the slot image, the requests, the overlap flag and the pending read.
- R10: A frame begins with the bit sampled on the first bit-clock falling edge at which the frame marker is seen high after being low. A new rising frame marker in mid-frame restarts the frame without committing the partial one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| bclk_i | input | 1 | Link bit clock, sampled by clk_i |
| sync_i | input | 1 | Frame marker |
| sdi_i | input | 2 | Serial data; bit 0 primary codec, bit 1 secondary |
| rd_req_i | input | 1 | Register read request strobe |
| rd_addr_i | input | 8 | Read address; bit 7 selects the codec line, bits 6..0 the register |
| rd_busy_o | output | 1 | Link read pending |
| rd_done_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 16 | Read data |
| gpio_shadow_o | output | 16 | Last received GPIO word |
| frame_o | output | 1 | One-cycle pulse when a frame's results are updated |
| ready_o | output | 2 | Per-line codec ready flags |
| slot_valid_o | output | 12 | Merged slot valid, bit k-1 for slot k |
| slot_data_o | output | 240 | Merged slot words, slot k at bits (k-1)*20 +: 20 |
| overlap_o | output | 1 | Both lines tagged the same slot in the last frame |
| slot_req_o | output | 10 | Merged slot requests, bit j for slot 3+j |

## Verification
A GPIO shadow read and a frame commit can fall in the same cycle, and a new slot 12 value is then both written and read. The bench holds a GPIO read request high across the end of a frame that carries a new slot 12 word. It then judges every response: a response before the frame pulse must carry the old shadow, one that coincides with the pulse or follows it must carry the new one, and exactly one response must coincide. The link read completion also falls on the frame pulse, and the bench checks that coincidence for every link read.

// File: rtl/ac_rx_pkg.sv
package ac_rx_pkg;
  localparam int unsigned NIN    = 2;
  localparam int unsigned NSLOT  = 12;
  localparam int unsigned SW     = 20;
  localparam int unsigned S0W    = 16;
  localparam int unsigned DW     = 16;
  localparam int unsigned ADDRW  = 8;
  localparam int unsigned RQW    = NSLOT - 2;
  localparam int unsigned IDX_HI = 18;
  localparam int unsigned IDX_LO = 12;
  localparam int unsigned REQ_HI = 11;
  localparam int unsigned DAT_HI = 19;
  localparam int unsigned DAT_LO = DAT_HI - DW + 1;
  localparam logic [IDX_HI-IDX_LO:0] GPIO_IDX = 7'h54;

  typedef logic [NSLOT:0][SW-1:0] frame_t;
endpackage

// File: rtl/ac_rx_bitclk.sv
module ac_rx_bitclk
  import ac_rx_pkg::*;
#(
  parameter int unsigned NIN_P = NIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             sync_i,
  input  logic [NIN_P-1:0] sdi_i,
  output logic             act_o,
  output logic             last_o,
  output logic [3:0]       slot_o,
  output logic [NIN_P-1:0] sdi_o,
  output logic             frame_end_o
);
  logic             bclk_q1, bclk_q2, sync_q, sync_prev_q, act_q;
  logic [NIN_P-1:0] sdi_q;
  logic [3:0]       slot_q, cur_slot;
  logic [4:0]       pos_q, cur_pos, len_m1;
  logic             bit_en, start, in_frame, last;

  assign bit_en   = bclk_q2 & ~bclk_q1;
  assign start    = bit_en & sync_q & ~sync_prev_q;
  assign in_frame = start | act_q;
  assign cur_slot = start ? 4'd0 : slot_q;
  assign cur_pos  = start ? 5'd0 : pos_q;
  assign len_m1   = (cur_slot == 4'd0) ? 5'(S0W - 1) : 5'(SW - 1);
  assign last     = (cur_pos == len_m1);

  assign act_o       = bit_en & in_frame;
  assign last_o      = act_o & last;
  assign slot_o      = cur_slot;
  assign sdi_o       = sdi_q;
  assign frame_end_o = last_o & (cur_slot == 4'(NSLOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q1     <= 1'b0;
      bclk_q2     <= 1'b0;
      sync_q      <= 1'b0;
      sync_prev_q <= 1'b0;
      sdi_q       <= '0;
      act_q       <= 1'b0;
      slot_q      <= '0;
      pos_q       <= '0;
    end else begin
      bclk_q1 <= bclk_i;
      bclk_q2 <= bclk_q1;
      sync_q  <= sync_i;
      sdi_q   <= sdi_i;
      if (bit_en) begin
        sync_prev_q <= sync_q;
        if (in_frame) begin
          if (last) begin
            pos_q  <= '0;
            slot_q <= cur_slot + 4'd1;
            act_q  <= (cur_slot != 4'(NSLOT));
          end else begin
            pos_q  <= cur_pos + 5'd1;
            slot_q <= cur_slot;
            act_q  <= 1'b1;
          end
        end
      end
    end
  end

  // R10: slot counter stays inside the frame
  a_r10_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (slot_q <= 4'(NSLOT)));
  // R10: a rising marker restarts at slot 0, second bit
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (act_q && slot_q == 4'd0 && pos_q == 5'd1));
endmodule

// File: rtl/ac_rx_deser.sv
module ac_rx_deser
  import ac_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       last_i,
  input  logic [3:0] slot_i,
  input  logic       sdi_i,
  output frame_t     words_o
);
  logic [SW-2:0] sh_q;
  logic [SW-1:0] nxt;
  frame_t        w_q;

  assign nxt     = {sh_q, sdi_i};
  assign words_o = w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      w_q  <= '0;
    end else begin
      if (act_i) sh_q <= nxt[SW-2:0];
      if (last_i) w_q[slot_i] <= nxt;
    end
  end
endmodule

// File: rtl/ac_rx_merge.sv
module ac_rx_merge
  import ac_rx_pkg::*;
#(
  parameter int unsigned NIN_P = NIN
) (
  input  frame_t                     f_i [NIN_P],
  output logic [NSLOT-1:0][SW-1:0]   slot_o,
  output logic [NSLOT-1:0]           valid_o,
  output logic                       overlap_o
);
  logic [NIN_P-1:0]      tag;
  logic [NIN_P-1:0][7:0] unused_hdr;

  for (genvar i = 0; i < NIN_P; i++) begin : g_sink
    assign unused_hdr[i] = {f_i[i][0][SW-1:S0W-1], f_i[i][0][2:0]};
  end

  always_comb begin
    slot_o    = '0;
    valid_o   = '0;
    overlap_o = 1'b0;
    tag       = '0;
    for (int k = 1; k <= NSLOT; k++) begin
      for (int i = 0; i < NIN_P; i++) tag[i] = f_i[i][0][S0W-1-k];
      valid_o[k-1] = |tag;
      if ($countones(tag) > 1) overlap_o = 1'b1;
      // descending scan: lowest-numbered line wins
      for (int i = NIN_P - 1; i >= 0; i--) if (tag[i]) slot_o[k-1] = f_i[i][k];
    end
  end
endmodule

// File: rtl/ac_dual_rx.sv
module ac_dual_rx
  import ac_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bclk_i,
  input  logic                 sync_i,
  input  logic [NIN-1:0]       sdi_i,
  input  logic                 rd_req_i,
  input  logic [ADDRW-1:0]     rd_addr_i,
  output logic                 rd_busy_o,
  output logic                 rd_done_o,
  output logic [DW-1:0]        rd_data_o,
  output logic [DW-1:0]        gpio_shadow_o,
  output logic                 frame_o,
  output logic [NIN-1:0]       ready_o,
  output logic [NSLOT-1:0]     slot_valid_o,
  output logic [NSLOT*SW-1:0]  slot_data_o,
  output logic                 overlap_o,
  output logic [RQW-1:0]       slot_req_o
);
  logic                   act, last, fend;
  logic [3:0]             slot;
  logic [NIN-1:0]         sdi_s;
  frame_t                 words [NIN];
  logic [NSLOT-1:0][SW-1:0] merged;
  logic [NSLOT-1:0]       mval;
  logic                   movl;

  ac_rx_bitclk #(.NIN_P(NIN)) u_bitclk (
    .clk_i, .rst_ni, .bclk_i, .sync_i, .sdi_i,
    .act_o(act), .last_o(last), .slot_o(slot), .sdi_o(sdi_s), .frame_end_o(fend)
  );

  for (genvar i = 0; i < NIN; i++) begin : g_line
    ac_rx_deser u_deser (
      .clk_i, .rst_ni, .act_i(act), .last_i(last), .slot_i(slot),
      .sdi_i(sdi_s[i]), .words_o(words[i])
    );
  end

  ac_rx_merge #(.NIN_P(NIN)) u_merge (
    .f_i(words), .slot_o(merged), .valid_o(mval), .overlap_o(movl)
  );

  logic                    commit_q, frame_q, ovl_q, pend_q, done_q;
  logic [NIN-1:0]          ready_q, ready_n;
  logic [NSLOT-1:0]        val_q;
  logic [NSLOT-1:0][SW-1:0] data_q;
  logic [RQW-1:0]          req_q, req_n;
  logic [DW-1:0]           shadow_q, shadow_n, rdata_q;
  logic [ADDRW-1:0]        pidx_q;

  always_comb begin
    req_n = '0;
    for (int i = 0; i < NIN; i++) begin
      ready_n[i] = words[i][0][S0W-1];
      for (int j = 0; j < RQW; j++)
        req_n[j] = req_n[j] | (ready_n[i] & ~words[i][1][REQ_HI-j]);
    end
  end

  logic                     sel, rsp_tag, rsp_ok, is_gpio, gpio_hit, link_go;
  logic [IDX_HI-IDX_LO:0]   rsp_idx;
  logic [DW-1:0]            rsp_dat;

  assign sel      = pidx_q[ADDRW-1];
  assign rsp_tag  = words[sel][0][S0W-2];
  assign rsp_idx  = words[sel][1][IDX_HI:IDX_LO];
  assign rsp_dat  = words[sel][2][DAT_HI:DAT_LO];
  assign rsp_ok   = commit_q & pend_q & rsp_tag & (rsp_idx == pidx_q[IDX_HI-IDX_LO:0]);
  assign is_gpio  = (rd_addr_i[IDX_HI-IDX_LO:0] == GPIO_IDX);
  assign gpio_hit = rd_req_i & ~pend_q & is_gpio;
  assign link_go  = rd_req_i & ~pend_q & ~is_gpio;
  // forward a slot 12 word committing this cycle (R8)
  assign shadow_n = (commit_q & mval[NSLOT-1]) ? merged[NSLOT-1][DAT_HI:DAT_LO] : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      frame_q  <= 1'b0;
      ready_q  <= '0;
      val_q    <= '0;
      data_q   <= '0;
      ovl_q    <= 1'b0;
      req_q    <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      pidx_q   <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      commit_q <= fend;
      frame_q  <= commit_q;
      done_q   <= 1'b0;
      if (commit_q) begin
        ready_q  <= ready_n;
        val_q    <= mval;
        data_q   <= merged;
        ovl_q    <= movl;
        req_q    <= req_n;
        shadow_q <= shadow_n;
      end
      if (rsp_ok) begin
        pend_q  <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= rsp_dat;
      end else if (gpio_hit) begin
        done_q  <= 1'b1;
        rdata_q <= shadow_n;
      end else if (link_go) begin
        pend_q <= 1'b1;
        pidx_q <= rd_addr_i;
      end
    end
  end

  assign rd_busy_o     = pend_q;
  assign rd_done_o     = done_q;
  assign rd_data_o     = rdata_q;
  assign gpio_shadow_o = shadow_q;
  assign frame_o       = frame_q;
  assign ready_o       = ready_q;
  assign slot_valid_o  = val_q;
  assign slot_data_o   = data_q;
  assign overlap_o     = ovl_q;
  assign slot_req_o    = req_q;

  a_r1_ready_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_q) |-> $past(commit_q));
  a_r7_shadow_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shadow_q) |-> $past(commit_q));
  a_r6_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !commit_q) |=> pend_q);
  a_r5_done_with_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> (rd_done_o && frame_o));
  a_r3_overlap_has_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> (slot_valid_o != '0));
endmodule

// File: tb/ac_dual_rx_tb.sv
`timescale 1ns/1ps
module ac_dual_rx_tb;
  import ac_rx_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, bclk, sync, rd_req;
  logic [1:0] sdi;
  logic [7:0] rd_addr;
  logic rd_busy, rd_done, frame, overlap;
  logic [15:0] rd_data, gshadow;
  logic [1:0] ready;
  logic [11:0] sval;
  logic [239:0] sdat;
  logic [9:0] sreq;

  ac_dual_rx u_dut (
    .clk_i(clk), .rst_ni, .bclk_i(bclk), .sync_i(sync), .sdi_i(sdi),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_busy_o(rd_busy), .rd_done_o(rd_done),
    .rd_data_o(rd_data), .gpio_shadow_o(gshadow), .frame_o(frame), .ready_o(ready),
    .slot_valid_o(sval), .slot_data_o(sdat), .overlap_o(overlap), .slot_req_o(sreq)
  );

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // frame spec
  logic        rdy [2];
  logic        tg  [2][1:12];
  logic [19:0] sw  [2][1:12];

  typedef struct packed {
    logic [1:0] rdy; logic [11:0] val; logic ovl; logic [9:0] req; logic [239:0] dat;
  } exp_t;
  typedef struct packed { logic [15:0] d; logic lnk; } rexp_t;
  exp_t  fq [$];
  rexp_t rq [$];
  logic [15:0] sh_model = '0;

  bit gwin = 0, g_seen = 0;
  int g_coinc = 0;
  logic [15:0] g_old, g_new;

  function automatic logic [19:0] mk_s1(input logic [6:0] idx, input logic [9:0] req_n);
    return {1'b0, idx, req_n, 2'b00};
  endfunction

  task automatic clear_spec();
    for (int i = 0; i < 2; i++) begin
      rdy[i] = 1'b1;
      for (int k = 1; k <= 12; k++) begin tg[i][k] = 1'b0; sw[i][k] = '0; end
      sw[i][1] = mk_s1(7'h00, 10'h3FF);
    end
  endtask

  function automatic logic [255:0] ser(input int i);
    logic [255:0] v;
    logic [15:0] s0;
    s0 = '0;
    s0[15] = rdy[i];
    for (int k = 1; k <= 12; k++) s0[15-k] = tg[i][k];
    v[255:240] = s0;
    for (int k = 1; k <= 12; k++) v[239-(k-1)*20 -: 20] = sw[i][k];
    return v;
  endfunction

  task automatic expect_frame();
    exp_t e;
    e = '0;
    e.rdy = {rdy[1], rdy[0]};
    for (int k = 1; k <= 12; k++) begin
      e.val[k-1] = tg[0][k] | tg[1][k];
      if (tg[0][k] && tg[1][k]) e.ovl = 1'b1;
      e.dat[(k-1)*20 +: 20] = tg[0][k] ? sw[0][k] : (tg[1][k] ? sw[1][k] : 20'h0);
    end
    for (int j = 0; j < 10; j++)
      e.req[j] = (rdy[0] & ~sw[0][1][11-j]) | (rdy[1] & ~sw[1][1][11-j]);
    if (e.val[11]) sh_model = e.dat[239:224];
    fq.push_back(e);
  endtask

  task automatic send(input int nbits, input bit push, input bit hold_gpio);
    logic [255:0] v0, v1;
    v0 = ser(0);
    v1 = ser(1);
    if (push) expect_frame();
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      if (hold_gpio && b == nbits - 1) begin rd_req = 1'b1; rd_addr = 8'h54; end
      bclk = 1'b1;
      sync = (b < 16);
      sdi  = {v1[255-b], v0[255-b]};
      @(negedge clk);
      @(negedge clk) bclk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int nbits);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk); bclk = 1'b1; sync = 1'b0; sdi = 2'b00;
      @(negedge clk);
      @(negedge clk) bclk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    idle(3);
    while (fq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic gpio_read(input logic [7:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    rq.push_back('{d: sh_model, lnk: 1'b0});
    @(negedge clk);
    check(rd_done == 1'b1, "R7 gpio read done next cycle", rd_done, 1);
    rd_req = 1'b0;
  endtask

  task automatic link_read(input logic [7:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_busy == 1'b1, "R5 busy after link read", rd_busy, 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (frame) begin
        if (fq.size() == 0) check(1'b0, "R10 unexpected frame pulse", 1, 0);
        else begin
          exp_t e;
          e = fq.pop_front();
          check(ready == e.rdy, "R1 ready flags", ready, e.rdy);
          check(sval == e.val, "R2 slot valid", sval, e.val);
          check(sdat == e.dat, "R2 slot data", sdat, e.dat);
          check(overlap == e.ovl, "R3 overlap flag", overlap, e.ovl);
          check(sreq == e.req, "R4 slot requests", sreq, e.req);
        end
      end
      if (rd_done) begin
        if (gwin) begin
          logic [15:0] ex;
          ex = (frame || g_seen) ? g_new : g_old;
          check(rd_data == ex, "R8 gpio read around commit", rd_data, ex);
          if (frame) begin g_coinc++; g_seen = 1; end
        end else if (rq.size() == 0) begin
          check(1'b0, "R6 unexpected read done", rd_data, 0);
        end else begin
          rexp_t r;
          r = rq.pop_front();
          check(rd_data == r.d, "R5 R7 read data", rd_data, r.d);
          if (r.lnk) check(frame == 1'b1, "R5 link done with frame pulse", frame, 1);
        end
      end
    end
  end

  bit done_flag = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; bclk = 0; sync = 0; sdi = 0; rd_req = 0; rd_addr = 0;
    repeat (5) @(negedge clk);
    check(ready == 0 && sval == 0 && rd_busy == 0 && gshadow == 0 && frame == 0,
          "R9 reset state", {ready, sval, rd_busy, gshadow}, 0);
    rst_ni = 1'b1;
    idle(2);

    // F1: basic merge, slot 12 from secondary
    clear_spec();
    tg[0][3] = 1; sw[0][3] = 20'h12345;
    tg[0][4] = 1; sw[0][4] = 20'hFEDCB;
    tg[1][5] = 1; sw[1][5] = 20'h0A0A0;
    tg[1][12] = 1; sw[1][12] = {16'hABCD, 4'h0};
    send(256, 1, 0);
    drain();
    check(gshadow == 16'hABCD, "R7 shadow captured", gshadow, 16'hABCD);
    gpio_read(8'h54);
    gpio_read(8'hD4);

    // link read, mismatched index ignored
    link_read(8'h26);
    clear_spec();
    tg[0][1] = 1; sw[0][1] = mk_s1(7'h30, 10'h3FF);
    tg[0][2] = 1; sw[0][2] = {16'h1111, 4'h0};
    send(256, 1, 0);
    drain();
    check(rd_busy == 1'b1, "R6 mismatched index ignored", rd_busy, 1);
    @(negedge clk); rd_req = 1'b1; rd_addr = 8'h12;
    @(negedge clk); rd_req = 1'b0;

    // tag clear but matching index; requests still decoded
    clear_spec();
    sw[0][1] = mk_s1(7'h26, 10'b0111011111);
    sw[1][1] = mk_s1(7'h00, 10'b1111111110);
    sw[0][2] = {16'h2222, 4'h0};
    send(256, 1, 0);
    drain();
    check(rd_busy == 1'b1, "R6 untagged read-back ignored", rd_busy, 1);

    // matching response
    clear_spec();
    tg[0][1] = 1; sw[0][1] = mk_s1(7'h26, 10'h3FF);
    tg[0][2] = 1; sw[0][2] = {16'h1234, 4'h0};
    rq.push_back('{d: 16'h1234, lnk: 1'b1});
    send(256, 1, 0);
    drain();
    check(rd_busy == 1'b0, "R5 busy falls after response", rd_busy, 0);

    // secondary read: response on wrong line ignored, then right line
    link_read(8'hA6);
    clear_spec();
    tg[0][1] = 1; sw[0][1] = mk_s1(7'h26, 10'h3FF);
    tg[0][2] = 1; sw[0][2] = {16'h7777, 4'h0};
    send(256, 1, 0);
    drain();
    check(rd_busy == 1'b1, "R6 response on other line ignored", rd_busy, 1);
    clear_spec();
    tg[1][1] = 1; sw[1][1] = mk_s1(7'h26, 10'h3FF);
    tg[1][2] = 1; sw[1][2] = {16'hBEEF, 4'h0};
    rq.push_back('{d: 16'hBEEF, lnk: 1'b1});
    send(256, 1, 0);
    drain();
    check(rd_busy == 1'b0, "R5 secondary read completes", rd_busy, 0);

    // overlap then clean frame, back to back
    clear_spec();
    tg[0][3] = 1; sw[0][3] = 20'h11111;
    tg[1][3] = 1; sw[1][3] = 20'h22222;
    tg[1][6] = 1; sw[1][6] = 20'h66666;
    send(256, 1, 0);
    clear_spec();
    tg[1][3] = 1; sw[1][3] = 20'h33333;
    send(256, 1, 0);
    drain();

    // not-ready line requests not counted
    clear_spec();
    rdy[1] = 1'b0; sw[1][1] = mk_s1(7'h00, 10'h000);
    sw[0][1] = mk_s1(7'h00, 10'b1111111101);
    send(256, 1, 0);
    drain();

    // R8: gpio read held across slot 12 commit
    clear_spec();
    tg[0][12] = 1; sw[0][12] = {16'h5A5A, 4'h0};
    g_old = sh_model; g_new = 16'h5A5A; g_seen = 0; g_coinc = 0;
    gwin = 1;
    send(256, 1, 1);
    repeat (12) @(negedge clk);
    rd_req = 1'b0;
    drain();
    gwin = 0;
    check(g_coinc == 1, "R8 one gpio response on commit cycle", g_coinc, 1);
    check(gshadow == 16'h5A5A, "R7 shadow updated", gshadow, 16'h5A5A);

    // R10: partial frame restarted by new marker
    clear_spec();
    for (int k = 1; k <= 12; k++) begin tg[0][k] = 1; sw[0][k] = 20'hFFFFF; end
    send(40, 0, 0);
    clear_spec();
    rdy[1] = 1'b0;
    tg[1][7] = 1; sw[1][7] = 20'h7ABC1;
    send(256, 1, 0);
    drain();
    check(sval == 12'h040, "R10 restart frame valid", sval, 12'h040);

    // R9: reset mid-run
    link_read(8'h40);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(rd_busy == 0 && ready == 0 && gshadow == 0 && sval == 0 && sreq == 0,
          "R9 cold reset clears state", {rd_busy, ready, gshadow, sval, sreq}, 0);
    rst_ni = 1'b1;
    sh_model = '0;
    gpio_read(8'h54);
    repeat (4) @(negedge clk);
    check(fq.size() == 0 && rq.size() == 0, "R5 scoreboard drained", fq.size() + rq.size(), 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule